// File: doc/BRIEF.md
# Dual-Output Multi-Mode PWM Generator

This block produces pulse-width-modulated waveforms on two output pins from one shared up-counter that runs on the core clock. A two-bit mode input picks one of four behaviours: off, a single waveform whose period and duty are both programmable over two bytes each, a pair of short-period waveforms where the second output is a window between two compare points, or a pair of waveforms over a fixed full-width period with independent duty values. Each output has an enable flag that tells the pad logic whether the pin is driven by the generator or left for general-purpose use.

Four byte-wide registers are written through a synchronous write port (enable, address, data). Writes land in shadow copies and reach the working copies only when the counter rolls over or the mode changes, so a cycle in progress is never cut short. The meaning of each register depends on the mode. With `REG_W` bits per register, the counter is `2*REG_W` bits wide.

Top module: `pwm_dual`

## Requirements
- R1: In mode 0 (mode input 00), and after reset, both outputs and both enable flags are low and the counter stays at 0; all four registers reset to 0.
- R2: In mode 1 (01), the cycle length is P = {reg3,reg2} counts, with P = 0 meaning 2^(2*REG_W); the counter runs 0 to P-1 and then wraps.
- R3: In mode 1, output B is high while the counter is below {reg1,reg0} and low otherwise; output A is not used and its enable flag is low.
- R4: The enable flag of output A is high exactly in modes 2 and 3; that of output B is high in modes 1, 2 and 3.
- R5: In mode 2 (10), the counter runs 0 to reg2 and wraps (reg2+1 counts per cycle); output A is high while the counter is below reg0.
- R6: In mode 2, output B is high while the counter is at or above reg3 and below reg1, so it rises at the reg3 match and falls at the reg1 match; reg3 = 0 starts it together with A.
- R7: In mode 3 (11), the counter wraps every 2^(2*REG_W) counts; A is high while the counter is below {reg1,reg0}, B while below {reg3,reg2}, and both are high together at count 0 when both compares are non-zero.
- R8: A compare value of 0 keeps its output low for a whole cycle; a compare value at or above the cycle length keeps it high for a whole cycle.
- R9: A write (register address 0 to 3) changes only a shadow copy; the working value switches at the next counter rollover or mode change, so the cycle in progress completes with the old values.
- R10: A change of the mode input resets the counter to 0, loads the shadow registers, and holds both outputs low for one clock; the new mode then starts at count 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Mode select: 0 off, 1 single variable, 2 twin short, 3 twin full |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index 0 to 3 |
| wr_data | input | REG_W | Register write data |
| pwm_a | output | 1 | Output A waveform |
| pwm_a_oe | output | 1 | Output A driven by the generator |
| pwm_b | output | 1 | Output B waveform |
| pwm_b_oe | output | 1 | Output B driven by the generator |

## Verification
The bench builds the block with REG_W = 4, so the counter is 8 bits and the full period of modes 1 and 3 is 256 clocks instead of 65536. That brings several complete full-width cycles, the zero-means-full-period case of mode 1, and rollover-timed register updates within a short run. A behavioural model of the counter, shadow loading and per-mode output rules is compared with all four outputs on every clock, and directed windows count high cycles per period to check duty, window edges and the one-clock blanking on mode change.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_VAR    = 2'd1,
    MODE_TWIN8  = 2'd2,
    MODE_TWIN16 = 2'd3
  } pwm_mode_e;

  localparam int NREG   = 4;
  localparam int ADDR_W = $clog2(NREG);

  // register roles, fixed by the mode decoding
  localparam int RI_A_LO = 0;
  localparam int RI_A_HI = 1;
  localparam int RI_B_LO = 2;
  localparam int RI_B_HI = 3;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_dual_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [REG_W-1:0]              wr_data,
  input  logic                          load,
  output logic [NREG-1:0][REG_W-1:0]    act
);
  logic [NREG-1:0][REG_W-1:0] shadow;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow[g] <= '0;
        act[g]    <= '0;
      end else begin
        if (hit)  shadow[g] <= wr_data;
        if (load) act[g]    <= shadow[g];
      end
    end
  end

  // working copy moves only on a load event
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(act));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_dual_pkg::*;
#(
  parameter int REG_W = 8,
  localparam int CW   = 2 * REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pwm_mode_e        mode_q,
  input  logic             restart,
  input  logic             blank,
  input  logic [REG_W-1:0] per_lo,
  input  logic [REG_W-1:0] per_hi,
  output logic [CW-1:0]    cnt,
  output logic             wrap
);
  // last count value of a cycle for each mode
  function automatic logic [CW-1:0] last_count(pwm_mode_e m,
                                               logic [REG_W-1:0] lo,
                                               logic [REG_W-1:0] hi);
    case (m)
      MODE_VAR:    last_count = {hi, lo} - CW'(1);
      MODE_TWIN8:  last_count = {{REG_W{1'b0}}, lo};
      MODE_TWIN16: last_count = '1;
      default:     last_count = '0;
    endcase
  endfunction

  logic [CW-1:0] last;
  assign last = last_count(mode_q, per_lo, per_hi);
  assign wrap = (mode_q != MODE_OFF) && !blank && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n)                                   cnt <= '0;
    else if (restart || blank || mode_q == MODE_OFF) cnt <= '0;
    else if (wrap)                                cnt <= '0;
    else                                          cnt <= cnt + CW'(1);
  end

  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OFF) |-> (cnt == '0));

  assert_twin8_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_TWIN8) |-> (cnt <= {{REG_W{1'b0}}, per_lo}));

  assert_blank_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> (cnt == '0));
endmodule

// File: rtl/pwm_outmux.sv
module pwm_outmux
  import pwm_dual_pkg::*;
#(
  parameter int REG_W = 8,
  localparam int CW   = 2 * REG_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  pwm_mode_e                  mode_q,
  input  logic                       blank,
  input  logic [CW-1:0]              cnt,
  input  logic [NREG-1:0][REG_W-1:0] act,
  output logic                       pwm_a,
  output logic                       pwm_b,
  output logic                       oe_a,
  output logic                       oe_b
);
  function automatic logic below(logic [CW-1:0] c, logic [CW-1:0] cmp);
    below = c < cmp;
  endfunction

  function automatic logic [CW-1:0] ext(logic [REG_W-1:0] v);
    ext = {{REG_W{1'b0}}, v};
  endfunction

  logic [CW-1:0] cmp_a16, cmp_b16;
  logic          a_raw, b_raw;

  assign cmp_a16 = {act[RI_A_HI], act[RI_A_LO]};
  assign cmp_b16 = {act[RI_B_HI], act[RI_B_LO]};

  always_comb begin
    a_raw = 1'b0;
    b_raw = 1'b0;
    case (mode_q)
      MODE_VAR:    b_raw = below(cnt, cmp_a16);
      MODE_TWIN8: begin
        a_raw = below(cnt, ext(act[RI_A_LO]));
        b_raw = !below(cnt, ext(act[RI_B_HI])) && below(cnt, ext(act[RI_A_HI]));
      end
      MODE_TWIN16: begin
        a_raw = below(cnt, cmp_a16);
        b_raw = below(cnt, cmp_b16);
      end
      default: ;
    endcase
  end

  assign pwm_a = a_raw && !blank;
  assign pwm_b = b_raw && !blank;
  assign oe_a  = (mode_q == MODE_TWIN8) || (mode_q == MODE_TWIN16);
  assign oe_b  = (mode_q != MODE_OFF);

  assert_blank_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (!pwm_a && !pwm_b));

  assert_off_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OFF) |-> (!oe_a && !oe_b && !pwm_a && !pwm_b));

  assert_var_a_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_VAR) |-> (!pwm_a && !oe_a));

  assert_sync_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_TWIN16 && !blank && cnt == '0 &&
     cmp_a16 != '0 && cmp_b16 != '0) |-> (pwm_a && pwm_b));
endmodule

// File: rtl/pwm_dual.sv
module pwm_dual
  import pwm_dual_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic              pwm_a,
  output logic              pwm_a_oe,
  output logic              pwm_b,
  output logic              pwm_b_oe
);
  localparam int CW = 2 * REG_W;

  pwm_mode_e                  mode_q;
  logic                       blank;
  logic                       restart;
  logic                       wrap;
  logic                       load;
  logic [CW-1:0]              cnt;
  logic [NREG-1:0][REG_W-1:0] act;

  assign restart = (pwm_mode_e'(mode) != mode_q);
  assign load    = restart || wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      blank  <= 1'b0;
    end else begin
      mode_q <= pwm_mode_e'(mode);
      blank  <= restart;
    end
  end

  pwm_regs #(.REG_W(REG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .load(load), .act(act)
  );

  pwm_counter #(.REG_W(REG_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .restart(restart),
    .blank(blank), .per_lo(act[RI_B_LO]), .per_hi(act[RI_B_HI]),
    .cnt(cnt), .wrap(wrap)
  );

  pwm_outmux #(.REG_W(REG_W)) u_out (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .blank(blank), .cnt(cnt),
    .act(act), .pwm_a(pwm_a), .pwm_b(pwm_b), .oe_a(pwm_a_oe), .oe_b(pwm_b_oe)
  );

  assert_mode_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (blank && !pwm_a && !pwm_b));
endmodule

// File: tb/test_pwm_dual.sv
module test_pwm_dual;
  localparam int W    = 4;
  localparam int FULL = 1 << (2 * W);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic         pwm_a, pwm_a_oe, pwm_b, pwm_b_oe;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  pwm_dual #(.REG_W(W)) i_pwm_dual (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_a(pwm_a), .pwm_a_oe(pwm_a_oe),
    .pwm_b(pwm_b), .pwm_b_oe(pwm_b_oe)
  );

  task automatic check(input string req, input int act_v, input int exp_v);
    n_tests++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_mode = 0, m_cnt = 0;
  bit m_blank = 0;
  int sh[4] = '{0, 0, 0, 0};
  int ac[4] = '{0, 0, 0, 0};

  function automatic int m_last();
    int p;
    case (m_mode)
      1: begin p = ac[3] * (1 << W) + ac[2]; if (p == 0) p = FULL; return p - 1; end
      2: return ac[2];
      3: return FULL - 1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_blank = 0;
      foreach (sh[i]) begin sh[i] = 0; ac[i] = 0; end
    end else begin
      if (int'(mode) != m_mode) begin
        m_mode = int'(mode); m_cnt = 0; m_blank = 1; ac = sh;
      end else if (m_blank) begin
        m_blank = 0; m_cnt = 0;
      end else if (m_mode == 0) begin
        m_cnt = 0;
      end else if (m_cnt == m_last()) begin
        m_cnt = 0; ac = sh;
      end else begin
        m_cnt++;
      end
      if (wr_en) sh[wr_addr] = int'(wr_data);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      int ea, eb, ea_oe, eb_oe, da, db;
      string tag;
      da = ac[1] * (1 << W) + ac[0];
      db = ac[3] * (1 << W) + ac[2];
      ea = 0; eb = 0;
      ea_oe = (m_mode >= 2); eb_oe = (m_mode != 0);
      case (m_mode)
        1: eb = (m_cnt < da);
        2: begin ea = (m_cnt < ac[0]); eb = (m_cnt >= ac[3]) && (m_cnt < ac[1]); end
        3: begin ea = (m_cnt < da); eb = (m_cnt < db); end
        default: ;
      endcase
      if (m_blank) begin ea = 0; eb = 0; end
      case (m_mode)
        1: tag = "R3 model";
        2: tag = "R6 model";
        3: tag = "R7 model";
        default: tag = "R1 model";
      endcase
      if (m_blank) tag = "R10 model";
      check(tag, {pwm_a, pwm_b, pwm_a_oe, pwm_b_oe}, {ea[0], eb[0], ea_oe[0], eb_oe[0]});
    end
  end

  // ---------------- stimulus helpers (all start at a negedge) ----------------
  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic enter_mode(input int m);
    mode = 2'(m);
    @(negedge clk);
  endtask

  task automatic run(input int n, input bit dow, input int wa, input int wd,
                     output int ha, output int hb, output bit first_both);
    ha = 0; hb = 0; first_both = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == 0) first_both = pwm_a && pwm_b;
      ha += int'(pwm_a); hb += int'(pwm_b);
      if (dow && k == 1) begin wr_en = 1'b1; wr_addr = 2'(wa); wr_data = W'(wd); end
      if (dow && k == 2) wr_en = 1'b0;
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    int ha, hb;
    bit fb;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {pwm_a, pwm_b, pwm_a_oe, pwm_b_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // mode 1, period 10, duty 3, then duty raised mid-cycle
    wr(0, 3); wr(1, 0); wr(2, 10); wr(3, 0);
    enter_mode(1);
    check("R10 blank after mode change", {pwm_a, pwm_b}, 0);
    check("R4 enables in mode 1", {pwm_a_oe, pwm_b_oe}, 2'b01);
    run(10, 1, 0, 8, ha, hb, fb);
    check("R9 old duty kept in current cycle", hb, 3);
    check("R3 output A idle in mode 1", ha, 0);
    run(10, 0, 0, 0, ha, hb, fb);
    check("R9 new duty after rollover", hb, 8);
    run(10, 0, 0, 0, ha, hb, fb);
    check("R2 period of 10 counts", hb, 8);

    // compare 0 and compare beyond period
    enter_mode(0);
    check("R1 enables released in mode 0", {pwm_a_oe, pwm_b_oe}, 0);
    wr(0, 0);
    enter_mode(1); run(10, 0, 0, 0, ha, hb, fb);
    check("R8 compare 0 low all cycle", hb, 0);
    enter_mode(0); wr(0, 12);
    enter_mode(1); run(20, 0, 0, 0, ha, hb, fb);
    check("R8 compare above period high all cycle", hb, 20);

    // mode 1 with period register 0 = full 2^(2W)
    enter_mode(0); wr(0, 8); wr(1, 12); wr(2, 0); wr(3, 0);
    enter_mode(1); run(FULL, 0, 0, 0, ha, hb, fb);
    check("R2 zero period means full width", hb, 200);

    // mode 2: period reg2+1 = 10, A < 4, B in [2,7)
    enter_mode(0); wr(0, 4); wr(1, 7); wr(2, 9); wr(3, 2);
    enter_mode(2);
    check("R4 enables in mode 2", {pwm_a_oe, pwm_b_oe}, 2'b11);
    run(10, 0, 0, 0, ha, hb, fb);
    check("R5 output A high count", ha, 4);
    check("R6 window high count", hb, 5);
    run(20, 0, 0, 0, ha, hb, fb);
    check("R5 period reg2+1 over two cycles", ha, 8);
    check("R6 window over two cycles", hb, 10);

    // mode 3: A 0x80 of 256, B 0x40 of 256
    enter_mode(0); wr(0, 0); wr(1, 8); wr(2, 0); wr(3, 4);
    enter_mode(3);
    check("R10 blank entering mode 3", {pwm_a, pwm_b}, 0);
    run(FULL, 0, 0, 0, ha, hb, fb);
    check("R7 both high at count 0", int'(fb), 1);
    check("R7 output A duty", ha, 128);
    check("R7 output B duty", hb, 64);
    run(FULL, 0, 0, 0, ha, hb, fb);
    check("R7 second cycle starts together", int'(fb), 1);

    enter_mode(0);
    @(negedge clk);
    finish_up();
  end
endmodule